// File: doc/BRIEF.md
# Multi-Register Load Sequencer

This block carries out a block load from memory into the register file. It receives a 16-bit selection list, a starting address from the address-generation logic, a size bit and a flag for the post-increment addressing mode. It walks the list from the lowest bit to the highest. For every selected register it reads one operand over a request/acknowledge bus and writes the result into the register file through a single write port.

A long operand is fetched as two word bus cycles. The bus address advances by one word after every acknowledged word, so the address moves by the operand size for each register loaded. In post-increment mode the address reached after the last transfer is written back into the base address register. A single-cycle completion pulse ends every accepted request.

Top module: `regload_seq`

## Requirements
- R1: A `start` with `to_regs`=1 is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the transfer ends. A `start` while `busy` is high, or with `to_regs`=0, has no effect on any output.
- R2: List bit i selects register index i on `rf_idx`, where indices 0–7 are D0–D7 and 8–15 are A0–A7. Registers are written in ascending index order, one `rf_we` pulse each.
- R3: The first bus read uses `base_addr`. Every acknowledged word read moves `bus_addr` up by 2, so each loaded register advances the address by 2 (word) or 4 (long).
- R4: With `long_sz`=1, each register takes two word reads. The first word goes to bits 31:16 of `rf_data` and the word read at address+2 goes to bits 15:0.
- R5: With `long_sz`=0, the 16-bit word read is sign-extended to 32 bits on `rf_data`.
- R6: `bus_req` stays high with a stable `bus_addr` until `bus_ack`. With a responder that acknowledges each word in its 4th cycle, a list needing W word reads issues its last acknowledgement 4·W cycles after acceptance.
- R7: With `post_inc`=1, after the last register one more `rf_we` writes index 8+`base_reg` with the value `base_addr` + (register count × operand size).
- R8: An all-zero list produces no bus request, no register write and no write-back. `done` pulses in the cycle after acceptance.
- R9: `done` is high for exactly one cycle, with `busy` low. It rises in the cycle after the last register write, or after the write-back when `post_inc`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer |
| to_regs | input | 1 | Direction bit, 1 = memory to registers (only direction served) |
| long_sz | input | 1 | Operand size, 0 = word, 1 = long |
| post_inc | input | 1 | Post-increment addressing mode |
| base_reg | input | 3 | Address register holding the base |
| reg_list | input | 16 | Register selection list |
| base_addr | input | AW | Starting address |
| bus_req | output | 1 | Word read request |
| bus_addr | output | AW | Word read address |
| bus_ack | input | 1 | Read acknowledge, data valid |
| bus_rdata | input | 16 | Read data |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 4 | Register file write index |
| rf_data | output | 32 | Register file write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The memory responder acknowledges each word in the fourth cycle that the request has been high. As a result, a list needing W word reads finishes with `done` visible in the cycle 4·W+1 after acceptance, or 4·W+2 when a write-back follows. An empty list finishes in cycle 1. The bench counts falling edges from acceptance and compares `done` against these figures. It checks each register write on the falling edge in which `rf_we` is high, against an index and a value computed from the list, the size and an address-derived memory pattern. One falling edge after `done`, it confirms that the number of writes matches and that both `busy` and `done` are low. A second `start` is injected in the middle of one transfer, and a `start` with the wrong direction bit is issued. In both cases the bench watches the outputs over the following cycles.

// File: rtl/regload_seq.sv
module regload_seq #(
  parameter int AW    = 24,
  parameter int LISTW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   to_regs,
  input  logic                   long_sz,
  input  logic                   post_inc,
  input  logic [$clog2(LISTW)-2:0] base_reg,
  input  logic [LISTW-1:0]       reg_list,
  input  logic [AW-1:0]          base_addr,
  output logic                   bus_req,
  output logic [AW-1:0]          bus_addr,
  input  logic                   bus_ack,
  input  logic [15:0]            bus_rdata,
  output logic                   rf_we,
  output logic [$clog2(LISTW)-1:0] rf_idx,
  output logic [31:0]            rf_data,
  output logic                   busy,
  output logic                   done
);
  localparam int IW = $clog2(LISTW);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WBACK} state_t;

  state_t          st;
  logic [LISTW-1:0] pend;
  logic [AW-1:0]   addr;
  logic            is_long, pinc, second;
  logic [IW-2:0]   breg;
  logic [15:0]     hi_word;
  logic [IW-1:0]   cur_idx;
  logic [LISTW-1:0] pend_next;

  always_comb begin
    cur_idx = '0;
    for (int i = LISTW - 1; i >= 0; i--)
      if (pend[i]) cur_idx = IW'(i);
  end

  assign pend_next = pend & (pend - 1'b1);
  assign bus_req   = (st == S_READ);
  assign bus_addr  = addr;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pend    <= '0;
      addr    <= '0;
      is_long <= 1'b0;
      pinc    <= 1'b0;
      second  <= 1'b0;
      breg    <= '0;
      hi_word <= '0;
      rf_we   <= 1'b0;
      rf_idx  <= '0;
      rf_data <= '0;
      done    <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (start && to_regs) begin
          addr    <= base_addr;
          pend    <= reg_list;
          is_long <= long_sz;
          pinc    <= post_inc;
          breg    <= base_reg;
          second  <= 1'b0;
          if (reg_list == '0) done <= 1'b1;
          else                st   <= S_READ;
        end
        S_READ: if (bus_ack) begin
          addr <= addr + AW'(2);
          if (is_long && !second) begin
            hi_word <= bus_rdata;
            second  <= 1'b1;
          end else begin
            second  <= 1'b0;
            rf_we   <= 1'b1;
            rf_idx  <= cur_idx;
            rf_data <= is_long ? {hi_word, bus_rdata} : {{16{bus_rdata[15]}}, bus_rdata};
            pend    <= pend_next;
            if (pend_next == '0) begin
              if (pinc) st <= S_WBACK;
              else begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            end
          end
        end
        S_WBACK: begin
          rf_we   <= 1'b1;
          rf_idx  <= {1'b1, breg};
          rf_data <= 32'(addr);
          st      <= S_IDLE;
          done    <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && to_regs && !busy && reg_list != '0) |=> busy);

  assert_ignore_wrong_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && to_regs)) |=> (!busy && !done && !rf_we));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> (!bus_req || bus_addr == $past(bus_addr) + AW'(2)));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/regload_seq_test.sv
`timescale 1ns/1ps
module regload_seq_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, to_regs = 1'b1, long_sz = 1'b0, post_inc = 1'b0;
  logic [2:0]    base_reg = '0;
  logic [15:0]   reg_list = '0;
  logic [AW-1:0] base_addr = '0;
  logic          bus_req;
  logic [AW-1:0] bus_addr;
  logic          bus_ack = 1'b0;
  logic [15:0]   bus_rdata = '0;
  logic          rf_we;
  logic [3:0]    rf_idx;
  logic [31:0]   rf_data;
  logic          busy, done;

  regload_seq #(.AW(AW), .LISTW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_regs(to_regs), .long_sz(long_sz),
    .post_inc(post_inc), .base_reg(base_reg), .reg_list(reg_list), .base_addr(base_addr),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int exp_n, got_k;
  logic [3:0]  exp_idx [0:16];
  logic [31:0] exp_dat [0:16];

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return {a[8:1] ^ 8'hC3, a[8:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : responder
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        cnt = bus_req ? 1 : 0;
      end else if (bus_req) begin
        cnt++;
        if (cnt == 4) begin
          bus_ack   = 1'b1;
          bus_rdata = mem_word(bus_addr);
        end
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && rf_we) begin
        if (got_k < exp_n) begin
          chk(rf_idx == exp_idx[got_k], "R2 order/index", 32'(rf_idx), 32'(exp_idx[got_k]));
          chk(rf_data == exp_dat[got_k], "R3/R4/R5/R7 data", rf_data, exp_dat[got_k]);
        end else
          chk(1'b0, "R2 extra write", 32'(got_k), 32'(exp_n));
        got_k++;
      end
    end
  end

  task automatic run_op(input logic [15:0] lst, input bit lng, input bit pinc,
                        input logic [2:0] br, input logic [AW-1:0] base, input bit disturb);
    logic [AW-1:0] a = base;
    int words = 0, n = 0, lat;
    exp_n = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        exp_idx[exp_n] = 4'(i);
        if (lng) exp_dat[exp_n] = {mem_word(a), mem_word(a + 2)};
        else     exp_dat[exp_n] = {{16{mem_word(a)[15]}}, mem_word(a)};
        a = a + (lng ? 4 : 2);
        words += lng ? 2 : 1;
        exp_n++;
      end
    end
    if (pinc && lst != 0) begin
      exp_idx[exp_n] = {1'b1, br};
      exp_dat[exp_n] = 32'(a);
      exp_n++;
    end
    lat = (lst == 0) ? 1 : 4 * words + 1 + (pinc ? 1 : 0);
    @(negedge clk);
    got_k = 0;
    reg_list = lst; long_sz = lng; post_inc = pinc; base_reg = br; base_addr = base;
    to_regs = 1'b1; start = 1'b1;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (disturb && n == 3) begin
        start = 1'b1; reg_list = 16'hFFFF; base_addr = 24'h000400;
      end
    end while (!done && n < 1000);
    start = 1'b0;
    chk(n == lat, "R6/R8/R9 done latency", 32'(n), 32'(lat));
    @(negedge clk);
    chk(got_k == exp_n, "R2/R7/R8 write count", 32'(got_k), 32'(exp_n));
    chk(!busy && !done, "R9 single pulse, idle", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] lists [0:7];
    lists[0] = 16'h0000; lists[1] = 16'h0001; lists[2] = 16'h8000; lists[3] = 16'h0101;
    lists[4] = 16'hFFFF; lists[5] = 16'h00F0; lists[6] = 16'hA55A; lists[7] = 16'h8001;
    exp_n = 0; got_k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_req && !rf_we, "R1 reset state",
        {28'd0, busy, done, bus_req, rf_we}, 32'd0);

    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          run_op(lists[m], s[0], p[0], 3'(m), 24'h000100 + 24'(m * 24'h60 + s * 24'h12 + p * 24'h6), 1'b0);

    run_op(16'h0303, 1'b1, 1'b1, 3'd5, 24'h000A00, 1'b1);

    @(negedge clk);
    got_k = 0; exp_n = 0;
    reg_list = 16'hFFFF; to_regs = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 6; c++) begin
      chk(!busy && !done && !bus_req && !rf_we, "R1 wrong direction ignored",
          {28'd0, busy, done, bus_req, rf_we}, 32'd0);
      @(negedge clk);
    end
    to_regs = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule